// File: doc/BRIEF.md
# Read Tag Allocator and Completion Tracker

This block sits on the requester side of a DMA read engine. When the engine wants to issue a memory read, it presents the byte address within the 4 KB page, the byte length and a DW offset into a destination buffer. If the request is legal and resources are available, the block grants it in the same cycle and returns a tag. Granting a request reserves a tag and enough buffer space for the whole read. Completions can never be refused, so space is reserved before the request goes out.

Incoming completion headers are matched by tag. Completions of different requests may interleave. Completions of the same request arrive in rising address order. For each matched successful completion, the block reports where in the buffer the completion's first data DW belongs and how many DWs follow. It then advances that tag's write pointer. A completion counts as the final one when its DW length equals ((low address & 3) + byte count + 3) >> 2. On the final completion the block reports done with the tag, and it frees the tag and its buffer reservation. A completion with a bad status, or one that carries a tag that is not outstanding, raises the error output.

Top module: `rd_tag_tracker`

## Requirements
- R1: A request is refused (req_grant low, nothing allocated) when its byte length is zero, exceeds MRRS_BYTES (default 512), or when page offset plus length exceeds 4096.
- R2: A granted request receives the lowest-numbered free tag; req_tag[7:5] is always zero.
- R3: When all 32 tags are outstanding, every request is refused.
- R4: A request needs ((page_off & 3) + bytes + 3) >> 2 DWs of buffer space. It is refused when that exceeds the unreserved space (BUF_DW, default 512, after reset). The reservation is returned when the request's final or error completion arrives.
- R5: One cycle after a completion with status 0 on an outstanding tag, wr_valid is high. wr_ptr is then the request's buffer offset plus the DW lengths of its earlier completions (modulo the buffer size), and wr_count is the completion's DW length.
- R6: When such a completion is final (length == ((low address & 3) + byte count + 3) >> 2), done pulses one cycle later with done_tag, and the tag becomes free.
- R7: A completion with nonzero status on an outstanding tag gives err one cycle later, with no wr_valid and no done. It frees the tag and its reservation.
- R8: A completion whose tag has nonzero upper bits or is not outstanding gives err one cycle later and changes no tag, pointer or reservation.
- R9: A tag or buffer space freed by a completion becomes available to requests only in the following cycle. When a request and a freeing completion share a cycle, both take effect.
- R10: After reset all tags are free, the full buffer is unreserved, and wr_valid, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request presented |
| req_page_off | input | 12 | Byte address of the read within its 4 KB page |
| req_bytes | input | 13 | Read length in bytes |
| req_buf_off | input | BUF_AW | Destination buffer DW offset |
| req_grant | output | 1 | Request accepted this cycle |
| req_tag | output | 8 | Tag for the granted request |
| cpl_valid | input | 1 | Completion header presented |
| cpl_tag | input | 8 | Completion tag |
| cpl_len | input | 10 | Completion DW length (0 means 1024) |
| cpl_bcnt | input | 13 | Bytes remaining including this completion |
| cpl_byte_off | input | 2 | Low two bits of the completion's lower address |
| cpl_status | input | 3 | Completion status, 0 is success |
| wr_valid | output | 1 | Steering information valid |
| wr_ptr | output | BUF_AW | Buffer DW index of the completion's first data DW |
| wr_count | output | 11 | Number of data DWs in the completion |
| done | output | 1 | Final completion of a request received |
| done_tag | output | 5 | Tag of the finished request |
| err | output | 1 | Bad status or unknown tag seen |

## Verification
Two functions can fall in the same cycle: allocating a tag and buffer space for a new request, and freeing a tag and its reservation on a final completion. The bench provokes this by driving both inputs at once while every tag is busy, and again while the buffer is fully reserved. It judges that the request is refused in that cycle and granted the freed tag in the next. After the buffer case, a further small request is still refused, which shows that the release and the new reservation both reached the space counter.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    localparam int TAG_BITS = 5;
    localparam int NUM_TAGS = 1 << TAG_BITS;
    localparam int BCNT_W   = 13;
    localparam int LEN_W    = 10;
    localparam int DWC_W    = 11;

    typedef logic [TAG_BITS-1:0] tag_t;
    typedef logic [DWC_W-1:0]    dwc_t;

    typedef struct packed {
        logic [7:0]        tag;
        logic [LEN_W-1:0]  len;
        logic [BCNT_W-1:0] bcnt;
        logic [1:0]        boff;
        logic [2:0]        status;
    } cpl_hdr_t;

    // DW length field with the zero-means-maximum encoding expanded
    function automatic dwc_t len_dws(input logic [LEN_W-1:0] len);
        return (len == '0) ? dwc_t'(1024) : dwc_t'(len);
    endfunction

    // DWs touched by a byte span starting at a given offset within a DW
    function automatic dwc_t span_dws(input logic [1:0] off, input logic [BCNT_W-1:0] bytes);
        logic [BCNT_W:0] s;
        s = {{(BCNT_W-1){1'b0}}, off} + {1'b0, bytes} + 14'd3;
        return s[BCNT_W-1:2];
    endfunction

    function automatic logic is_final(input cpl_hdr_t h);
        return len_dws(h.len) == span_dws(h.boff, h.bcnt);
    endfunction
endpackage

// File: rtl/rtt_tag_pool.sv
module rtt_tag_pool
    import rtt_pkg::*;
#(
    parameter int N = NUM_TAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         alloc_en,
    input  logic         free_en,
    input  tag_t         free_idx,
    output logic [N-1:0] busy,
    output logic         any_free,
    output tag_t         pick
);
    logic [N-1:0] busy_q;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_q[i]) pick = tag_t'(i);
        end
    end

    assign any_free = ~&busy_q;
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            if (free_en)  busy_q[free_idx] <= 1'b0;
            if (alloc_en) busy_q[pick]     <= 1'b1;
        end
    end

    assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !busy_q[pick]);
    assert_free_was_busy_R6: assert property (@(posedge clk) disable iff (rst)
        free_en |-> busy_q[free_idx]);
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (&busy_q) |-> !alloc_en);
endmodule

// File: rtl/rtt_credit.sv
module rtt_credit
    import rtt_pkg::*;
#(
    parameter int BUF_DW = 512
) (
    input  logic clk,
    input  logic rst,
    input  dwc_t need,
    input  logic take_en,
    input  logic give_en,
    input  dwc_t give_amt,
    output logic ok
);
    localparam int CW = $clog2(BUF_DW + 1);
    logic [CW-1:0] avail_q;

    assign ok = 32'(need) <= 32'(avail_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q <= CW'(BUF_DW);
        end else begin
            avail_q <= CW'(32'(avail_q) + (give_en ? 32'(give_amt) : 32'd0)
                                        - (take_en ? 32'(need)     : 32'd0));
        end
    end

    assert_within_capacity_R4: assert property (@(posedge clk) disable iff (rst)
        32'(avail_q) <= BUF_DW);
    assert_take_covered_R4: assert property (@(posedge clk) disable iff (rst)
        take_en |-> 32'(need) <= 32'(avail_q));
endmodule

// File: rtl/rtt_ctx.sv
module rtt_ctx
    import rtt_pkg::*;
#(
    parameter int N      = NUM_TAGS,
    parameter int BUF_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  tag_t              wr_idx,
    input  logic [BUF_AW-1:0] wr_off,
    input  dwc_t              wr_rsv,
    input  logic              adv_en,
    input  tag_t              rd_idx,
    input  dwc_t              adv_amt,
    output logic [BUF_AW-1:0] rd_ptr,
    output dwc_t              rd_rsv
);
    logic [BUF_AW-1:0] ptr_q [N];
    dwc_t              rsv_q [N];

    assign rd_ptr = ptr_q[rd_idx];
    assign rd_rsv = rsv_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                ptr_q[i] <= '0;
                rsv_q[i] <= '0;
            end
        end else begin
            if (adv_en) ptr_q[rd_idx] <= ptr_q[rd_idx] + BUF_AW'(adv_amt);
            if (wr_en) begin
                ptr_q[wr_idx] <= wr_off;
                rsv_q[wr_idx] <= wr_rsv;
            end
        end
    end

    assert_no_slot_clash_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adv_en) |-> (wr_idx != rd_idx));
endmodule

// File: rtl/rd_tag_tracker.sv
module rd_tag_tracker
    import rtt_pkg::*;
#(
    parameter int BUF_DW     = 512,
    parameter int MRRS_BYTES = 512,
    parameter int BUF_AW     = $clog2(BUF_DW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [11:0]       req_page_off,
    input  logic [12:0]       req_bytes,
    input  logic [BUF_AW-1:0] req_buf_off,
    output logic              req_grant,
    output logic [7:0]        req_tag,
    input  logic              cpl_valid,
    input  logic [7:0]        cpl_tag,
    input  logic [9:0]        cpl_len,
    input  logic [12:0]       cpl_bcnt,
    input  logic [1:0]        cpl_byte_off,
    input  logic [2:0]        cpl_status,
    output logic              wr_valid,
    output logic [BUF_AW-1:0] wr_ptr,
    output logic [10:0]       wr_count,
    output logic              done,
    output logic [4:0]        done_tag,
    output logic              err
);
    localparam int PAGE_BYTES = 4096;

    cpl_hdr_t            hdr;
    tag_t                cpl_idx, pick;
    logic [NUM_TAGS-1:0] busy;
    logic                any_free, buf_ok, legal;
    logic                hit, good, bad, last, free_en;
    dwc_t                need, rsv;
    logic [BUF_AW-1:0]   cur_ptr;

    assign hdr     = '{tag: cpl_tag, len: cpl_len, bcnt: cpl_bcnt,
                       boff: cpl_byte_off, status: cpl_status};
    assign cpl_idx = hdr.tag[TAG_BITS-1:0];

    // request side
    assign need  = span_dws(req_page_off[1:0], req_bytes);
    assign legal = (req_bytes != '0)
                && (32'(req_bytes) <= MRRS_BYTES)
                && (32'(req_page_off) + 32'(req_bytes) <= PAGE_BYTES);
    assign req_grant = req_valid && legal && any_free && buf_ok;
    assign req_tag   = {3'b000, pick};

    // completion side
    assign hit     = cpl_valid && (hdr.tag[7:TAG_BITS] == '0) && busy[cpl_idx];
    assign good    = hit && (hdr.status == 3'd0);
    assign bad     = hit && (hdr.status != 3'd0);
    assign last    = good && is_final(hdr);
    assign free_en = last || bad;

    rtt_tag_pool #(.N(NUM_TAGS)) u_pool (
        .clk(clk), .rst(rst),
        .alloc_en(req_grant), .free_en(free_en), .free_idx(cpl_idx),
        .busy(busy), .any_free(any_free), .pick(pick)
    );

    rtt_credit #(.BUF_DW(BUF_DW)) u_credit (
        .clk(clk), .rst(rst),
        .need(need), .take_en(req_grant),
        .give_en(free_en), .give_amt(rsv),
        .ok(buf_ok)
    );

    rtt_ctx #(.N(NUM_TAGS), .BUF_AW(BUF_AW)) u_ctx (
        .clk(clk), .rst(rst),
        .wr_en(req_grant), .wr_idx(pick), .wr_off(req_buf_off), .wr_rsv(need),
        .adv_en(good), .rd_idx(cpl_idx), .adv_amt(len_dws(hdr.len)),
        .rd_ptr(cur_ptr), .rd_rsv(rsv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_ptr   <= '0;
            wr_count <= '0;
            done     <= 1'b0;
            done_tag <= '0;
            err      <= 1'b0;
        end else begin
            wr_valid <= good;
            wr_ptr   <= cur_ptr;
            wr_count <= len_dws(hdr.len);
            done     <= last;
            done_tag <= cpl_idx;
            err      <= cpl_valid && !good;
        end
    end

    assert_unknown_tag_R8: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !hit) |=> (err && !wr_valid && !done));
    assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_valid && !err));
    assert_tag_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        req_grant |-> (req_tag[7:5] == 3'b000));
endmodule

// File: tb/rd_tag_tracker_bench.sv
module rd_tag_tracker_bench;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [11:0]   req_page_off;
    logic [12:0]   req_bytes;
    logic [AW-1:0] req_buf_off;
    logic          req_grant;
    logic [7:0]    req_tag;
    logic          cpl_valid;
    logic [7:0]    cpl_tag;
    logic [9:0]    cpl_len;
    logic [12:0]   cpl_bcnt;
    logic [1:0]    cpl_byte_off;
    logic [2:0]    cpl_status;
    logic          wr_valid;
    logic [AW-1:0] wr_ptr;
    logic [10:0]   wr_count;
    logic          done;
    logic [4:0]    done_tag;
    logic          err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rd_tag_tracker u_rd_tag_tracker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_page_off(req_page_off), .req_bytes(req_bytes),
        .req_buf_off(req_buf_off), .req_grant(req_grant), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_len(cpl_len),
        .cpl_bcnt(cpl_bcnt), .cpl_byte_off(cpl_byte_off), .cpl_status(cpl_status),
        .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_count(wr_count),
        .done(done), .done_tag(done_tag), .err(err)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic set_req(input int off, input int bytes, input int boff);
        req_valid    = 1'b1;
        req_page_off = 12'(off);
        req_bytes    = 13'(bytes);
        req_buf_off  = AW'(boff);
    endtask

    task automatic set_cpl(input int tag, input int len, input int bcnt,
                           input int boff, input int st);
        cpl_valid    = 1'b1;
        cpl_tag      = 8'(tag);
        cpl_len      = 10'(len);
        cpl_bcnt     = 13'(bcnt);
        cpl_byte_off = 2'(boff);
        cpl_status   = 3'(st);
    endtask

    // one request cycle; grant and tag are checked before the edge
    task automatic issue(input string r, input int off, input int bytes, input int boff,
                         input bit exp_g, input int exp_tag);
        @(negedge clk);
        set_req(off, bytes, boff);
        #1;
        chk(r, "req_grant", int'(req_grant), int'(exp_g));
        if (exp_g) chk(r, "req_tag", int'(req_tag), exp_tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // one completion cycle; registered outputs checked one cycle later
    task automatic complete(input string r, input int tag, input int len, input int bcnt,
                            input int boff, input int st, input bit exp_wr, input int exp_ptr,
                            input bit exp_done, input bit exp_err);
        @(negedge clk);
        set_cpl(tag, len, bcnt, boff, st);
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk(r, "wr_valid", int'(wr_valid), int'(exp_wr));
        if (exp_wr) begin
            chk(r, "wr_ptr", int'(wr_ptr), exp_ptr);
            chk(r, "wr_count", int'(wr_count), (len == 0) ? 1024 : len);
        end
        chk(r, "done", int'(done), int'(exp_done));
        if (exp_done) chk(r, "done_tag", int'(done_tag), tag & 31);
        chk(r, "err", int'(err), int'(exp_err));
    endtask

    task automatic t_reset;
        #1;
        chk("R10", "wr_valid", int'(wr_valid), 0);
        chk("R10", "done", int'(done), 0);
        chk("R10", "err", int'(err), 0);
        issue("R10", 0, 2048, 0, 1'b0, 0);   // exceeds MRRS, must not allocate
        issue("R10", 0, 4, 0, 1'b1, 0);
        complete("R10", 0, 1, 4, 0, 0, 1'b1, 0, 1'b1, 1'b0);
    endtask

    task automatic t_basic;
        issue("R2", 12'h000, 16, 10, 1'b1, 0);
        issue("R2", 12'h100, 256, 100, 1'b1, 1);
        complete("R5", 1, 32, 256, 0, 0, 1'b1, 100, 1'b0, 1'b0);
        complete("R6", 0, 4, 16, 0, 0, 1'b1, 10, 1'b1, 1'b0);
        complete("R5", 1, 32, 128, 0, 0, 1'b1, 132, 1'b1, 1'b0);
        // unaligned start: 2 + 8 bytes span 3 DWs
        issue("R2", 12'h002, 8, 40, 1'b1, 0);
        complete("R6", 0, 3, 8, 2, 0, 1'b1, 40, 1'b1, 1'b0);
    endtask

    task automatic t_illegal;
        issue("R1", 12'h000, 0, 0, 1'b0, 0);
        issue("R1", 12'h000, 516, 0, 1'b0, 0);
        issue("R1", 12'hFFC, 8, 0, 1'b0, 0);
        issue("R1", 12'hF00, 256, 7, 1'b1, 0);
        complete("R1", 0, 64, 256, 0, 0, 1'b1, 7, 1'b1, 1'b0);
    endtask

    task automatic t_buffer;
        for (int i = 0; i < 4; i++) issue("R4", 0, 512, 128 * i, 1'b1, i);
        issue("R4", 0, 4, 0, 1'b0, 0);
        complete("R7", 2, 128, 512, 0, 4, 1'b0, 0, 1'b0, 1'b1);
        issue("R4", 0, 512, 256, 1'b1, 2);
        complete("R4", 0, 128, 512, 0, 0, 1'b1, 0, 1'b1, 1'b0);
        complete("R4", 1, 128, 512, 0, 0, 1'b1, 128, 1'b1, 1'b0);
        complete("R4", 2, 128, 512, 0, 0, 1'b1, 256, 1'b1, 1'b0);
        complete("R4", 3, 128, 512, 0, 0, 1'b1, 384, 1'b1, 1'b0);
    endtask

    task automatic t_unknown;
        complete("R8", 7, 1, 4, 0, 0, 1'b0, 0, 1'b0, 1'b1);
        issue("R8", 0, 8, 50, 1'b1, 0);
        complete("R8", 8'h20, 1, 8, 0, 0, 1'b0, 0, 1'b0, 1'b1);
        complete("R8", 0, 2, 8, 0, 0, 1'b1, 50, 1'b1, 1'b0);
    endtask

    task automatic t_exhaust;
        for (int i = 0; i < 32; i++) issue("R3", 0, 4, i, 1'b1, i);
        issue("R3", 0, 4, 0, 1'b0, 0);
        complete("R3", 5, 1, 4, 0, 0, 1'b1, 5, 1'b1, 1'b0);
        issue("R3", 0, 4, 5, 1'b1, 5);
    endtask

    task automatic t_same_cycle;
        // all tags busy: request and freeing completion together
        @(negedge clk);
        set_req(0, 4, 9);
        set_cpl(9, 1, 4, 0, 0);
        #1;
        chk("R9", "req_grant same cycle as tag free", int'(req_grant), 0);
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk("R9", "done", int'(done), 1);
        chk("R9", "req_grant next cycle", int'(req_grant), 1);
        chk("R9", "req_tag", int'(req_tag), 9);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 32; i++) complete("R9", i, 1, 4, 0, 0, 1'b1, i, 1'b1, 1'b0);
        // buffer fully reserved: release and reservation in one cycle
        for (int i = 0; i < 4; i++) issue("R9", 0, 512, 128 * i, 1'b1, i);
        @(negedge clk);
        set_req(0, 512, 300);
        set_cpl(1, 128, 512, 0, 0);
        #1;
        chk("R9", "req_grant same cycle as release", int'(req_grant), 0);
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk("R9", "req_grant after release", int'(req_grant), 1);
        chk("R9", "req_tag", int'(req_tag), 1);
        @(negedge clk);
        req_valid = 1'b0;
        issue("R9", 0, 4, 0, 1'b0, 0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_page_off = '0; req_bytes = '0; req_buf_off = '0;
        cpl_valid = 1'b0; cpl_tag = '0; cpl_len = '0; cpl_bcnt = '0;
        cpl_byte_off = '0; cpl_status = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_basic;
        t_illegal;
        t_buffer;
        t_unknown;
        t_exhaust;
        t_same_cycle;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule